// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block holds one programmed alarm word and compares it against the running calendar. The calendar is given as a packed BCD time word, a BCD day of month and a weekday number. Each of the four alarm fields (seconds, minutes, hours with a PM bit, and day) has its own "don't care" bit. The day field can be set to match either a day of month or a weekday. Month and year are never part of the match.

The comparison is made only in the clock cycle where the one-hertz tick is high, and only while the alarm is enabled. A full match on the unmasked fields sets a sticky alarm flag, and the interrupt output follows the flag while interrupts are enabled. Software clears the flag with a clear strobe. A parameter chooses the clear convention: either a zero is written to the flag, or a one is written to a separate clear location.

The stored alarm word may only be replaced while the write-allowed output is high. That output rises a fixed number of cycles after the alarm enable is dropped, and it falls at once when the enable is raised again. Write strobes at any other time are dropped.

Top module: `bcd_alarm_match`

## Requirements
- R1: The alarm word holds BCD seconds in bits 6:0, BCD minutes in bits 14:8, and BCD hours in bits 21:16 with a PM bit at 22. The time input uses the same bit positions. When the alarm is enabled and every unmasked field equals its input, a tick sets the alarm flag one cycle later.
- R2: Bit 7 masks seconds, bit 15 masks minutes, bit 23 masks hours together with the PM bit, and bit 31 masks the day. A masked field does not affect the match result.
- R3: When bit 30 is 1, bits 27:24 are compared with the weekday input (1 to 7, zero-extended), and the day of month is ignored. When bit 30 is 0, bits 29:24 are compared with the BCD day of month, and the weekday is ignored.
- R4: The flag is set only in a cycle where the tick is high and the alarm enable is 1. A matching time with no tick, or a tick while the enable is 0, leaves the flag clear.
- R5: The flag stays set until a clear strobe arrives. With CLEAR_W1C=0, a strobe clears the flag only when its data bit is 0. With CLEAR_W1C=1, it clears the flag only when its data bit is 1. A strobe with the other data value has no effect. If a set and a clear fall in the same cycle, the set wins.
- R6: The interrupt output is high exactly when the flag is set and the interrupt enable is 1.
- R7: The write-allowed output is 0 while the alarm enable is 1. It becomes 1 WA_DELAY cycles after the enable is sampled 0 (the default is 2).
- R8: An alarm write strobe is accepted only while write-allowed is 1. A rejected write leaves the stored alarm word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second; the comparison is made only in this cycle |
| time_word | input | 23 | BCD seconds [6:0], minutes [14:8], hours [21:16], PM [22] |
| day_of_month | input | 6 | BCD day of month |
| weekday | input | 3 | Weekday, 1 to 7 |
| alarm_word | input | 32 | New alarm word |
| alarm_wr | input | 1 | Write strobe for alarm_word |
| alarm_en | input | 1 | Alarm enable |
| irq_en | input | 1 | Alarm interrupt enable |
| clr_wr | input | 1 | Flag clear strobe |
| clr_data | input | 1 | Data bit carried with the clear strobe |
| alarm_flag | output | 1 | Sticky alarm flag |
| wr_allowed | output | 1 | Alarm word may be written |
| irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume a few things about the inputs:
- The tick is a single-cycle pulse.
- The enables and strobes are synchronous to clk.
- Software raises alarm_en only after its alarm write has been issued.

The stimulus drives every input on the falling edge and holds each tick for exactly one cycle. It drops the enable, waits for write-allowed before every accepted write, and aims deliberate stray writes at windows where write-allowed is low. The time and day values it applies are legal BCD within calendar range, so only the effect of the mask and select bits is being tested.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
   // Three time fields share one width: seconds, minutes, hours+PM.
   localparam int TF_N = 3;
   localparam int TF_W = 7;

   localparam int DAY_LO  = 24;
   localparam int DATE_W  = 6;
   localparam int WDAY_W  = 4;
   localparam int WSEL_B  = 30;
   localparam int DAYM_B  = 31;

   function automatic int tf_lo(input int idx);
      return idx * 8;
   endfunction

   function automatic int tf_mask(input int idx);
      return idx * 8 + 7;
   endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
   parameter int W = 7
) (
   input  logic [W-1:0] ref_v,
   input  logic [W-1:0] cur_v,
   input  logic         ignore,
   output logic         hit
);
   always_comb hit = ignore || (ref_v == cur_v);
endmodule

// File: rtl/alarm_day_sel.sv
module alarm_day_sel
   import alarm_pkg::*;
(
   input  logic [DATE_W-1:0] ref_day,
   input  logic              wday_sel,
   input  logic              ignore,
   input  logic [DATE_W-1:0] dom,
   input  logic [2:0]        wday,
   output logic              hit
);
   logic [WDAY_W-1:0] wd_ext;
   logic              date_eq;
   logic              wday_eq;

   always_comb begin
      wd_ext  = {{(WDAY_W-3){1'b0}}, wday};
      date_eq = (ref_day == dom);
      wday_eq = (ref_day[WDAY_W-1:0] == wd_ext);
      hit     = ignore || (wday_sel ? wday_eq : date_eq);
   end
endmodule

// File: rtl/alarm_wr_gate.sv
module alarm_wr_gate #(
   parameter int WA_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm_en,
   output logic wr_allowed
);
   localparam int CW = $clog2(WA_DELAY + 1);
   localparam logic [CW-1:0] LIMIT = CW'(WA_DELAY);

   generate
      if (WA_DELAY < 1) begin : g_bad_delay
         $error("WA_DELAY must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (alarm_en)        cnt_q <= '0;
      else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
   end

   always_comb wr_allowed = (cnt_q == LIMIT) && !alarm_en;

   // R7: write-allowed can only rise after the enable was seen low
   a_r7_rise_after_disable : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_allowed) |-> $past(!alarm_en));

   // R7: a disable lasting one cycle is not enough
   a_r7_no_early_grant : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(alarm_en) && !alarm_en) |-> !wr_allowed);
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
   import alarm_pkg::*;
#(
   parameter int WA_DELAY  = 2,
   parameter bit CLEAR_W1C = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sec_tick,
   input  logic [22:0] time_word,
   input  logic [5:0]  day_of_month,
   input  logic [2:0]  weekday,
   input  logic [31:0] alarm_word,
   input  logic        alarm_wr,
   input  logic        alarm_en,
   input  logic        irq_en,
   input  logic        clr_wr,
   input  logic        clr_data,
   output logic        alarm_flag,
   output logic        wr_allowed,
   output logic        irq
);
   logic [31:0]     alarm_q;
   logic [TF_N-1:0] tf_hit;
   logic            day_hit;
   logic            full_hit;
   logic            set_ev;
   logic            clr_hit;

   alarm_wr_gate #(.WA_DELAY(WA_DELAY)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .alarm_en   (alarm_en),
      .wr_allowed (wr_allowed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      alarm_q <= '0;
      else if (alarm_wr && wr_allowed) alarm_q <= alarm_word;
   end

   for (genvar i = 0; i < TF_N; i++) begin : g_tf
      alarm_field_cmp #(.W(TF_W)) u_cmp (
         .ref_v  (alarm_q[tf_lo(i) +: TF_W]),
         .cur_v  (time_word[tf_lo(i) +: TF_W]),
         .ignore (alarm_q[tf_mask(i)]),
         .hit    (tf_hit[i])
      );
   end

   alarm_day_sel u_day (
      .ref_day  (alarm_q[DAY_LO +: DATE_W]),
      .wday_sel (alarm_q[WSEL_B]),
      .ignore   (alarm_q[DAYM_B]),
      .dom      (day_of_month),
      .wday     (weekday),
      .hit      (day_hit)
   );

   always_comb begin
      full_hit = (&tf_hit) && day_hit;
      set_ev   = sec_tick && alarm_en && full_hit;
   end

   if (CLEAR_W1C) begin : g_clr_w1c
      always_comb clr_hit = clr_wr && clr_data;
   end else begin : g_clr_w0c
      always_comb clr_hit = clr_wr && !clr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       alarm_flag <= 1'b0;
      else if (set_ev)  alarm_flag <= 1'b1;
      else if (clr_hit) alarm_flag <= 1'b0;
   end

   always_comb irq = alarm_flag && irq_en;

   // R4: flag rises only after an enabled tick
   a_r4_rise_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(sec_tick && alarm_en));

   // R5: flag holds without a clear
   a_r5_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !clr_hit) |=> alarm_flag);

   // R5: set beats clear in the same cycle
   a_r5_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && clr_hit) |=> alarm_flag);

   // R6: interrupt needs the flag
   a_r6_irq_needs_flag : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (alarm_flag && irq_en));

   // R8: stored word changes only on an accepted write
   a_r8_word_guarded : assert property (@(posedge clk) disable iff (!rst_n)
      !(alarm_wr && wr_allowed) |=> $stable(alarm_q));
endmodule

// File: tb/tb_bcd_alarm_match.sv
module tb_bcd_alarm_match;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic [22:0] time_word = '0;
   logic [5:0]  day_of_month = 6'h01;
   logic [2:0]  weekday = 3'd1;
   logic [31:0] alarm_word = '0;
   logic        alarm_wr = 1'b0;
   logic        alarm_en = 1'b0;
   logic        irq_en = 1'b0;
   logic        clr_wr = 1'b0;
   logic        clr_data = 1'b0;
   logic        clr2_data = 1'b0;
   logic        flag, wa, irq;
   logic        flag2, wa2, irq2;

   int nchk = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   bcd_alarm_match #(.WA_DELAY(2), .CLEAR_W1C(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .time_word(time_word),
      .day_of_month(day_of_month), .weekday(weekday), .alarm_word(alarm_word),
      .alarm_wr(alarm_wr), .alarm_en(alarm_en), .irq_en(irq_en),
      .clr_wr(clr_wr), .clr_data(clr_data),
      .alarm_flag(flag), .wr_allowed(wa), .irq(irq));

   bcd_alarm_match #(.WA_DELAY(2), .CLEAR_W1C(1'b1)) dut_w1c (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .time_word(time_word),
      .day_of_month(day_of_month), .weekday(weekday), .alarm_word(alarm_word),
      .alarm_wr(alarm_wr), .alarm_en(alarm_en), .irq_en(irq_en),
      .clr_wr(clr_wr), .clr_data(clr2_data),
      .alarm_flag(flag2), .wr_allowed(wa2), .irq(irq2));

   localparam int NV = 12;
   localparam logic [31:0] V_ALM [NV] = '{
      32'h15123045, 32'h15123045, 32'h151230C5, 32'h151230C5,
      32'h80808080, 32'h45080000, 32'h45080000, 32'h05080000,
      32'h80470000, 32'h80470000, 32'h80911000, 32'h8010A233};
   localparam logic [22:0] V_TIME [NV] = '{
      23'h123045, 23'h123046, 23'h123059, 23'h123159,
      23'h235959, 23'h080000, 23'h080000, 23'h080000,
      23'h470000, 23'h070000, 23'h051000, 23'h105933};
   localparam logic [5:0] V_DOM [NV] = '{
      6'h15, 6'h15, 6'h15, 6'h15, 6'h31, 6'h22,
      6'h05, 6'h05, 6'h01, 6'h01, 6'h02, 6'h03};
   localparam logic [2:0] V_WD [NV] = '{
      3'd3, 3'd3, 3'd3, 3'd3, 3'd7, 3'd5,
      3'd4, 3'd4, 3'd1, 3'd1, 3'd2, 3'd6};
   localparam logic V_EXP [NV] = '{
      1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1,
      1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
   localparam int V_REQ [NV] = '{1, 1, 2, 2, 2, 3, 3, 3, 1, 1, 2, 2};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic program_alarm(input logic [31:0] w);
      alarm_en = 1'b0;
      do @(negedge clk); while (!wa);
      alarm_word = w;
      alarm_wr   = 1'b1;
      @(negedge clk);
      alarm_wr = 1'b0;
      alarm_en = 1'b1;
   endtask

   task automatic set_cal(input logic [22:0] t, input logic [5:0] d, input logic [2:0] w);
      time_word = t; day_of_month = d; weekday = w;
   endtask

   task automatic pulse_tick();
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic clear_both();
      clr_wr = 1'b1; clr_data = 1'b0; clr2_data = 1'b1;
      @(negedge clk);
      clr_wr = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset flag R5", flag, 0);
      chk("reset irq R6", irq, 0);

      // Vector table: R1 R2 R3 R6
      irq_en = 1'b1;
      for (int i = 0; i < NV; i++) begin
         program_alarm(V_ALM[i]);
         set_cal(V_TIME[i], V_DOM[i], V_WD[i]);
         pulse_tick();
         chk($sformatf("vec%0d R%0d flag", i, V_REQ[i]), flag, V_EXP[i]);
         chk($sformatf("vec%0d R%0d flag w1c", i, V_REQ[i]), flag2, V_EXP[i]);
         chk($sformatf("vec%0d irq R6", i), irq, V_EXP[i]);
         clear_both();
         chk($sformatf("vec%0d clear R5", i), flag | flag2, 0);
      end

      // R7: write-allowed timing
      alarm_en = 1'b1;
      @(negedge clk);
      chk("R7 low while enabled", wa, 0);
      alarm_en = 1'b0;
      @(negedge clk);
      chk("R7 low after 1 cycle", wa, 0);
      @(negedge clk);
      chk("R7 high after 2 cycles", wa, 1);
      alarm_en = 1'b1;
      #1;
      chk("R7 drops on enable", wa, 0);

      // R8: rejected writes leave the word unchanged
      program_alarm(32'h15123045);
      alarm_word = 32'h80808080; alarm_wr = 1'b1;
      @(negedge clk);
      alarm_wr = 1'b0;
      set_cal(23'h000000, 6'h01, 3'd1);
      pulse_tick();
      chk("R8 write while enabled ignored", flag, 0);
      alarm_en = 1'b0; alarm_word = 32'h80808080; alarm_wr = 1'b1;
      @(negedge clk);
      alarm_wr = 1'b0; alarm_en = 1'b1;
      pulse_tick();
      chk("R8 early write ignored", flag, 0);
      set_cal(23'h123045, 6'h15, 3'd3);
      pulse_tick();
      chk("R8 old word still matches", flag, 1);
      clear_both();

      // R4: tick and enable gating
      repeat (3) @(negedge clk);
      chk("R4 no tick no set", flag, 0);
      alarm_en = 1'b0;
      pulse_tick();
      chk("R4 disabled tick no set", flag, 0);
      alarm_en = 1'b1;
      pulse_tick();
      chk("R4 enabled tick sets", flag, 1);
      set_cal(23'h000000, 6'h01, 3'd1);
      pulse_tick();
      repeat (2) @(negedge clk);
      chk("R5 flag sticky", flag, 1);

      // R5: wrong-polarity clears do nothing
      clr_wr = 1'b1; clr_data = 1'b1; clr2_data = 1'b0;
      @(negedge clk);
      clr_wr = 1'b0;
      chk("R5 w0c ignores data 1", flag, 1);
      chk("R5 w1c ignores data 0", flag2, 1);
      clear_both();
      chk("R5 w0c clears", flag, 0);
      chk("R5 w1c clears", flag2, 0);

      // R5: set wins over clear
      set_cal(23'h123045, 6'h15, 3'd3);
      clr_wr = 1'b1; clr_data = 1'b0; clr2_data = 1'b1;
      pulse_tick();
      clr_wr = 1'b0;
      chk("R5 set wins w0c", flag, 1);
      chk("R5 set wins w1c", flag2, 1);

      // R6: interrupt enable gating
      irq_en = 1'b0;
      #1;
      chk("R6 irq masked", irq, 0);
      irq_en = 1'b1;
      #1;
      chk("R6 irq follows flag", irq, 1);
      clear_both();
      chk("R6 irq low after clear", irq, 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule